// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This controller sits between a simple host request port and one asynchronous fast-page-mode DRAM whose row and column addresses share a 10-bit multiplexed bus. It sequences the row strobe, column strobe, write enable and output enable from a single system clock (33 MHz class). Every analog timing minimum is expressed as a whole number of clock cycles:

- row-strobe-to-data time,
- column strobe low and high widths,
- precharge time,
- minimum row-active time for refresh.

A host issues one of three requests: a single-word write, a single-word read, or a four-word line read. A line read keeps the row open and pulses only the column strobe once per word. A free-running interval timer raises a refresh request, and a row-only refresh cycle then services it. Each refresh advances an internal row pointer, so all rows are covered in turn. A pending refresh waits for the access in flight to finish. It then goes ahead of any new host request.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, and `dram_dq_oe` and `rd_valid` are 0.
- R2: The row half of the host address (`req_addr[19:10]`) is on `dram_addr` when `dram_ras_n` falls. The column is on `dram_addr` when `dram_cas_n` falls. `dram_cas_n` is low only while `dram_ras_n` is low.
- R3: A read returns the word stored at the addressed row and column on `rd_data`, with a one-cycle `rd_valid` pulse. The pulse comes on the cycle `dram_cas_n` rises, and at least `T_RCD+T_CASL` cycles after `dram_ras_n` fell. Reads complete in issue order.
- R4: Once `dram_ras_n` rises, it stays high for at least `T_RP` cycles before it falls again.
- R5: A line read (`req_burst`=1, `req_write`=0) holds `dram_ras_n` low across exactly four column strobes, with `dram_cas_n` high for at least `T_CASH` cycles between them. It visits the columns `{col[9:2],2'b00}` to `{col[9:2],2'b11}` in ascending order and gives four `rd_valid` pulses.
- R6: On a write, `dram_we_n` is already low on the cycle before `dram_cas_n` falls and stays low while the column strobe is low. `dram_oe_n` stays high, and `dram_dq_oe` is 1 with `dram_dq_out` carrying the write data.
- R7: A refresh is requested every `REF_INTERVAL` cycles. It is serviced by a row-only cycle in which `dram_cas_n` stays high. The refresh rows run 0, 1, 2 and onward, wrapping from 1023 to 0.
- R8: A pending refresh lets the current access or line read finish and then runs before the next host request. Under continuous host traffic, two refresh starts are never more than `REF_INTERVAL+12` cycles apart.
- R9: `req_ready` is 1 only when no access is in progress and no refresh is pending. A request presented while `req_ready` is 0 is ignored and leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_write | input | 1 | 1 = single-word write, 0 = read |
| req_burst | input | 1 | With a read: four-word line read |
| req_addr | input | 20 | {row[9:0], column[9:0]} |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 16 | Read word |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
Different faults show up at different points:

- A wrong sequencer state or count shows up at the strobe pins in the same access. The symptoms are a column strobe outside an open row, a short precharge, a skipped or extra column in a line read, or data captured at the wrong edge. The DRAM model and the scoreboard catch these within a few cycles.
- A wrong burst column counter shows up as a column address mismatch on the next strobe.
- A corrupted refresh row pointer or interval timer shows up at the next refresh, as an out-of-order row or an overlong gap. Running past 1024 refreshes also checks the wrap.
- An ignored request that leaked into the memory is exposed by the read-back that follows it.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_CASL,
    ST_CASH,
    ST_PRE,
    ST_REF
  } fpm_state_t;

  function automatic int fpm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_refresh_sched.sv
module fpm_refresh_sched #(
  parameter int AW           = 10,
  parameter int REF_INTERVAL = 520
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_ack,
  output logic          ref_pending,
  output logic [AW-1:0] ref_row
);

  localparam int IW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

  logic [IW-1:0] tick_cnt;

  // interval timer: free running, one request per period
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt    <= '0;
      ref_pending <= 1'b0;
    end else begin
      if (ref_ack) ref_pending <= 1'b0;
      if (tick_cnt == IW'(REF_INTERVAL - 1)) begin
        tick_cnt    <= '0;
        ref_pending <= 1'b1;
      end else begin
        tick_cnt <= tick_cnt + IW'(1);
      end
    end
  end

  // row pointer covers all 2**AW rows and wraps
  always_ff @(posedge clk) begin
    if (rst) ref_row <= '0;
    else if (ref_ack) ref_row <= ref_row + AW'(1);
  end

endmodule

// File: rtl/fpm_strobe_seq.sv
module fpm_strobe_seq
  import fpm_pkg::*;
#(
  parameter int AW     = 10,
  parameter int DW     = 16,
  parameter int BEATS  = 4,
  parameter int T_RCD  = 1,
  parameter int T_CASL = 1,
  parameter int T_CASH = 1,
  parameter int T_RP   = 2,
  parameter int T_RAS  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_burst,
  input  logic [2*AW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  input  logic            ref_pending,
  input  logic [AW-1:0]   ref_row,
  output logic            ref_ack,
  output logic [AW-1:0]   dram_addr,
  output logic            dram_ras_n,
  output logic            dram_cas_n,
  output logic            dram_we_n,
  output logic            dram_oe_n,
  output logic [DW-1:0]   dram_dq_out,
  output logic            dram_dq_oe,
  input  logic [DW-1:0]   dram_dq_in
);

  localparam int BW   = $clog2(BEATS);
  localparam int TMAX = fpm_max(fpm_max(fpm_max(T_RCD, T_CASL), fpm_max(T_CASH, T_RP)), T_RAS);
  localparam int CW   = $clog2(TMAX + 1);

  fpm_state_t    state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] beat;
  logic [AW-1:0] col_q;
  logic          is_wr;
  logic          is_burst;
  logic          cnt_done;

  assign cnt_done  = (cnt == '0);
  assign req_ready = (state == ST_IDLE) && !ref_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      beat        <= '0;
      col_q       <= '0;
      is_wr       <= 1'b0;
      is_burst    <= 1'b0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      ref_ack     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      ref_ack  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pending) begin
            // row-only refresh cycle
            state      <= ST_REF;
            dram_ras_n <= 1'b0;
            dram_addr  <= ref_row;
            ref_ack    <= 1'b1;
            cnt        <= CW'(T_RAS - 1);
          end else if (req_valid) begin
            state       <= ST_ROW;
            dram_ras_n  <= 1'b0;
            dram_addr   <= req_addr[2*AW-1:AW];
            is_wr       <= req_write;
            is_burst    <= req_burst && !req_write;
            col_q       <= (req_burst && !req_write) ?
                           {req_addr[AW-1:BW], BW'(0)} : req_addr[AW-1:0];
            beat        <= '0;
            dram_we_n   <= !req_write;  // early write: WE low with the row
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            cnt         <= CW'(T_RCD - 1);
          end
        end
        ST_ROW: begin
          if (cnt_done) begin
            state      <= ST_CASL;
            dram_cas_n <= 1'b0;
            dram_addr  <= col_q;
            dram_oe_n  <= is_wr;
            cnt        <= CW'(T_CASL - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_CASL: begin
          if (cnt_done) begin
            dram_cas_n <= 1'b1;
            dram_oe_n  <= 1'b1;
            if (!is_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            if (is_burst && (beat != BW'(BEATS - 1))) begin
              // page mode: row stays open
              state <= ST_CASH;
              beat  <= beat + BW'(1);
              col_q <= col_q + AW'(1);
              cnt   <= CW'(T_CASH - 1);
            end else begin
              state      <= ST_PRE;
              dram_ras_n <= 1'b1;
              dram_we_n  <= 1'b1;
              dram_dq_oe <= 1'b0;
              cnt        <= CW'(T_RP - 1);
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_CASH: begin
          if (cnt_done) begin
            state      <= ST_CASL;
            dram_cas_n <= 1'b0;
            dram_addr  <= col_q;
            dram_oe_n  <= 1'b0;
            cnt        <= CW'(T_CASL - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_REF: begin
          if (cnt_done) begin
            state      <= ST_PRE;
            dram_ras_n <= 1'b1;
            cnt        <= CW'(T_RP - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_PRE: begin
          if (cnt_done) state <= ST_IDLE;
          else cnt <= cnt - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int AW           = 10,
  parameter int DW           = 16,
  parameter int BEATS        = 4,
  parameter int T_RCD        = 1,
  parameter int T_CASL       = 1,
  parameter int T_CASH       = 1,
  parameter int T_RP         = 2,
  parameter int T_RAS        = 2,
  parameter int REF_INTERVAL = 520
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_burst,
  input  logic [2*AW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   dram_addr,
  output logic            dram_ras_n,
  output logic            dram_cas_n,
  output logic            dram_we_n,
  output logic            dram_oe_n,
  output logic [DW-1:0]   dram_dq_out,
  output logic            dram_dq_oe,
  input  logic [DW-1:0]   dram_dq_in
);

  logic          ref_pending;
  logic          ref_ack;
  logic [AW-1:0] ref_row;

  fpm_refresh_sched #(
    .AW           (AW),
    .REF_INTERVAL (REF_INTERVAL)
  ) u_ref (
    .clk         (clk),
    .rst         (rst),
    .ref_ack     (ref_ack),
    .ref_pending (ref_pending),
    .ref_row     (ref_row)
  );

  fpm_strobe_seq #(
    .AW     (AW),
    .DW     (DW),
    .BEATS  (BEATS),
    .T_RCD  (T_RCD),
    .T_CASL (T_CASL),
    .T_CASH (T_CASH),
    .T_RP   (T_RP),
    .T_RAS  (T_RAS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_burst   (req_burst),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .ref_pending (ref_pending),
    .ref_row     (ref_row),
    .ref_ack     (ref_ack),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_out (dram_dq_out),
    .dram_dq_oe  (dram_dq_oe),
    .dram_dq_in  (dram_dq_in)
  );

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RP = 2
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rd_valid,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);

  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= 8'(T_RP);
    else if (!dram_ras_n) hi_cnt <= '0;
    else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
  end

  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n); // R2

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> hi_cnt >= 8'(T_RP)); // R4

  AST_WE_BEFORE_CAS: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R6

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> (dram_oe_n && dram_dq_oe)); // R6

  AST_RDVALID_AT_CAS_RISE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $rose(dram_cas_n)); // R3

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (dram_ras_n && dram_cas_n)); // R9

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RP(T_RP)) u_chk (.*);

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;

  localparam int AW = 10;
  localparam int DW = 16;
  localparam int T_RCD = 1;
  localparam int T_CASL = 1;
  localparam int T_RP = 2;
  localparam int REF_INT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic req_burst = 1'b0;
  logic [2*AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [DW-1:0] dram_dq_out;
  logic [DW-1:0] dram_dq_in = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  fpm_dram_ctrl #(.REF_INTERVAL(REF_INT)) u_fpm_dram_ctrl (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] patt(input int key);
    return DW'(key * 7 + 3);
  endfunction

  // scoreboard state
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] exp_rd [$];
  logic [2*AW-1:0] exp_addr [$];
  int exp_ncas [$];

  // ---------------- DRAM model ----------------
  logic [DW-1:0] mem [int];
  logic pr_ras = 1, pr_cas = 1, pr_we = 1, pr_oe = 1;
  int hi_cnt = 100;
  int cyc = 0, ras_cyc = 0, ncas = 0, last_ref = -1, n_ref = 0, exp_ref = 0;
  logic [AW-1:0] cur_row = '0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rst) begin
      if (pr_ras && !dram_ras_n) begin
        check(hi_cnt >= T_RP, "R4 precharge", hi_cnt, T_RP);
        cur_row = dram_addr;
        ncas = 0;
        ras_cyc = cyc;
      end
      if (pr_cas && !dram_cas_n) begin
        int key;
        check(!dram_ras_n, "R2 cas under ras", dram_ras_n, 0);
        ncas++;
        if (exp_addr.size() == 0) check(0, "R2 unexpected cas", dram_addr, 0);
        else begin
          logic [2*AW-1:0] ea;
          ea = exp_addr.pop_front();
          check({cur_row, dram_addr} == ea, "R2/R5 address", {cur_row, dram_addr}, ea);
        end
        key = int'({cur_row, dram_addr});
        if (!dram_we_n) begin
          check(!pr_we && dram_oe_n && dram_dq_oe, "R6 early write", {pr_we, dram_oe_n, dram_dq_oe}, 3'b011);
          mem[key] = dram_dq_out;
        end else begin
          dram_dq_in = mem.exists(key) ? mem[key] : patt(key);
        end
      end
      if (!pr_cas && dram_cas_n && !pr_oe)
        check(rd_valid && (cyc - ras_cyc >= T_RCD + T_CASL), "R3 sample time", cyc - ras_cyc, T_RCD + T_CASL);
      if (!pr_ras && dram_ras_n) begin
        if (ncas == 0) begin
          check(cur_row == AW'(exp_ref), "R7 refresh row", cur_row, exp_ref);
          exp_ref = (exp_ref + 1) % 1024;
          if (last_ref >= 0)
            check(ras_cyc - last_ref <= REF_INT + 12, "R8 refresh gap", ras_cyc - last_ref, REF_INT + 12);
          last_ref = ras_cyc;
          n_ref++;
        end else begin
          int en;
          en = (exp_ncas.size() != 0) ? exp_ncas.pop_front() : -1;
          check(ncas == en, "R5 strobes per row", ncas, en);
        end
      end
    end
    hi_cnt = dram_ras_n ? hi_cnt + 1 : 0;
    pr_ras = dram_ras_n; pr_cas = dram_cas_n; pr_we = dram_we_n; pr_oe = dram_oe_n;
  end

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_rd.size() == 0) check(0, "R3 unexpected rd_valid", rd_data, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_rd.pop_front();
        check(rd_data == e, "R3 read data", rd_data, e);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input bit wr, input bit bst, input logic [AW-1:0] row,
                        input logic [AW-1:0] col, input logic [DW-1:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_burst = bst;
    req_addr = {row, col}; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    if (wr) begin
      shadow[int'({row, col})] = wd;
      exp_addr.push_back({row, col});
      exp_ncas.push_back(1);
    end else if (bst) begin
      for (int k = 0; k < 4; k++) begin
        logic [2*AW-1:0] a;
        a = {row, col[AW-1:2], 2'(k)};
        exp_addr.push_back(a);
        exp_rd.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : patt(int'(a)));
      end
      exp_ncas.push_back(4);
    end else begin
      exp_addr.push_back({row, col});
      exp_rd.push_back(shadow.exists(int'({row, col})) ? shadow[int'({row, col})] : patt(int'({row, col})));
      exp_ncas.push_back(1);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 180000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", wd, 180000);
      summary();
    end
  end

  initial begin
    logic [31:0] lcg;
    repeat (4) @(negedge clk);
    // R1: reset state
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes idle",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!dram_dq_oe && !rd_valid, "R1 dq_oe/rd_valid", {dram_dq_oe, rd_valid}, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 after release",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(req_ready, "R9 ready when idle", req_ready, 1);

    // R6 writes, R3 single reads
    do_req(1, 0, 10'd5, 10'd17, 16'h1234);
    do_req(1, 0, 10'd1023, 10'd1023, 16'hBEEF);
    do_req(0, 0, 10'd5, 10'd17, '0);
    do_req(0, 0, 10'd1023, 10'd1023, '0);
    do_req(0, 0, 10'd3, 10'd0, '0);

    // R5 line read, start column 18 -> columns 16..19
    for (int k = 0; k < 4; k++) do_req(1, 0, 10'd9, AW'(16 + k), DW'(16'hA000 + k));
    do_req(0, 1, 10'd9, 10'd18, '0);
    do_req(0, 1, 10'd700, 10'd1021, '0);

    // R9: write presented while busy is ignored
    do_req(0, 1, 10'd2, 10'd8, '0);
    @(negedge clk);
    check(!req_ready, "R9 ready low while busy", req_ready, 0);
    req_valid = 1; req_write = 1; req_burst = 0; req_addr = {10'd44, 10'd44}; req_wdata = 16'hBAD0;
    @(negedge clk);
    req_valid = 0;
    do_req(0, 0, 10'd44, 10'd44, '0);

    // R8: continuous host traffic, refresh must still get in
    lcg = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      do_req(lcg[31], lcg[30] & ~lcg[31], lcg[29:20], lcg[19:10], lcg[15:0]);
    end

    // R7: idle until refresh row wraps past 1023
    while (n_ref < 1030) @(negedge clk);
    check(n_ref >= 1025 && exp_ref == n_ref % 1024, "R7 wrap", exp_ref, n_ref % 1024);
    repeat (20) @(negedge clk);
    check(exp_rd.size() == 0, "R3 all reads returned", exp_rd.size(), 0);
    check(exp_addr.size() == 0, "R2 all strobes seen", exp_addr.size(), 0);
    summary();
  end

endmodule